// File: doc/BRIEF.md
# Stacked Chip-Select Region Decoder

This block turns a flat read address inside a memory-mapped flash window into a target chip select and a byte offset inside that device. Four devices share the window. Each one owns a region whose length is set by a programmable size register. The regions are packed back to back, in a fixed order, starting at the bottom of the window.

No region base is ever programmed. The base of each region is the sum of the lengths of all regions below it. A region whose size is zero takes up no space, so its neighbours sit directly next to each other. An address that lies at or beyond the end of the last region is reported as a miss.

Size registers are loaded through a simple write port. A lookup is presented as an address with a valid strobe. The decision (chip select, offset and miss flag) appears one clock later on registered outputs.

Top module: `stacked_cs_decoder`

## Requirements
- R1: Regions are stacked from address 0 upward in the order chip select 0, 1, 2, 3. The base of region n is the sum of the byte lengths of regions 0 to n-1.
- R2: A size register counts in 1 KiB units, so the region length in bytes is the register value shifted left by 10. The full 23-bit value is honoured, including region ends above 4 GiB.
- R3: The size register for chip select n is written when `cfgWrEn` is high and `cfgAddr` equals 4n. A write with `cfgAddr[1:0]` not equal to zero, or with the address above 12, changes no size.
- R4: A region whose size is zero is never selected. An address at the shared boundary goes to the next non-empty region.
- R5: An address at or above the sum of all four region lengths sets `rspMiss`. On a miss, `rspCs` and `rspOffset` keep their previous values.
- R6: On a hit, `rspOffset` equals the address minus the base of the selected region.
- R7: `rspValid` rises exactly one cycle after each cycle with `reqValid` high, and is low otherwise. `rspMiss` is low whenever `rspValid` is low.
- R8: Reset clears every size register and drives `rspValid`, `rspMiss`, `rspCs` and `rspOffset` to zero. After reset every lookup misses.
- R9: A lookup in the same cycle as a size write is decoded with the sizes that were in place before that write. The new size applies from the next cycle.
- R10: The last byte of a region selects that region. The byte right after it selects the next non-empty region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Size register write strobe |
| cfgAddr | input | CFG_ADDR_W (4) | Byte offset of the size register being written |
| cfgWrData | input | SIZE_W (23) | Region size in KiB |
| reqValid | input | 1 | Lookup strobe |
| reqAddr | input | ADDR_W (32) | Address within the mapped window |
| rspValid | output | 1 | Lookup result valid, one cycle after `reqValid` |
| rspMiss | output | 1 | Address is beyond all configured regions |
| rspCs | output | 2 | Selected chip select |
| rspOffset | output | ADDR_W (32) | Byte offset inside the selected device |

## Verification
The assertions assume that `cfgWrData` is stable whenever `cfgWrEn` is high. They also assume that reset is held long enough for the registered outputs to clear before the first lookup is judged. The stimulus meets both assumptions: writes and lookups are driven only on falling edges, and reset is released after several cycles with both strobes held low.

The assertions on the selected region assume the address is compared against the region ends as they stand in that cycle. The stimulus covers this in several ways:
- It places lookups right after writes.
- It places a lookup in the same cycle as a write.
- It sets up empty regions in the middle of the stack.
- It programs one region large enough that the stack passes the top of the 32-bit address range, so that case is exercised without an address overflowing.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int CS_NUM   = 4;
  localparam int CS_IDX_W = $clog2(CS_NUM);
  localparam int REG_LSB  = 2;

  typedef struct packed {
    logic [CS_NUM-1:0] sizeLoad;
    logic              lookupFire;
  } ctrl_strobe_t;

endpackage

// File: rtl/csdec_ctrl.sv
module csdec_ctrl
  import csdec_pkg::*;
#(
  parameter int CFG_ADDR_W = 4
) (
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic                  reqValid,
  output ctrl_strobe_t          strobe
);

  localparam int IDX_HI = REG_LSB + CS_IDX_W;

  logic              wordAligned;
  logic              upperClear;
  logic [CS_IDX_W-1:0] regIdx;
  logic [CS_NUM-1:0] loadVec;

  assign wordAligned = (cfgAddr[REG_LSB-1:0] == '0);
  assign regIdx      = cfgAddr[IDX_HI-1:REG_LSB];

  generate
    if (CFG_ADDR_W > IDX_HI) begin : g_upper
      assign upperClear = ~|cfgAddr[CFG_ADDR_W-1:IDX_HI];
    end else begin : g_noUpper
      assign upperClear = 1'b1;
    end
  endgenerate

  // R3: one load strobe per chip select, only for aligned in-range offsets
  generate
    for (genvar g = 0; g < CS_NUM; g++) begin : g_load
      assign loadVec[g] = cfgWrEn && wordAligned && upperClear &&
                          (regIdx == CS_IDX_W'(g));
    end
  endgenerate

  assign strobe.sizeLoad   = loadVec;
  assign strobe.lookupFire = reqValid;

endmodule

// File: rtl/csdec_size_bank.sv
module csdec_size_bank
  import csdec_pkg::*;
#(
  parameter int SIZE_W   = 23,
  parameter int KB_SHIFT = 10,
  parameter int SPAN_W   = SIZE_W + KB_SHIFT + CS_IDX_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_strobe_t                   strobe,
  input  logic [SIZE_W-1:0]              cfgWrData,
  output logic [CS_NUM-1:0][SIZE_W-1:0]  sizeKb,
  output logic [CS_NUM-1:0][SPAN_W-1:0]  regionBase,
  output logic [CS_NUM-1:0][SPAN_W-1:0]  regionEnd
);

  logic [CS_NUM-1:0][SIZE_W-1:0] sizeQ;
  logic [CS_NUM-1:0][SPAN_W-1:0] spanBytes;

  // R8: all sizes clear on reset; R3: per-register load
  generate
    for (genvar g = 0; g < CS_NUM; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sizeQ[g] <= '0;
        end else if (strobe.sizeLoad[g]) begin
          sizeQ[g] <= cfgWrData;
        end
      end

      // R2: KiB units
      assign spanBytes[g] = SPAN_W'({sizeQ[g], {KB_SHIFT{1'b0}}});

      // R1: running sum forms the bases
      if (g == 0) begin : g_first
        assign regionBase[g] = '0;
      end else begin : g_next
        assign regionBase[g] = regionEnd[g-1];
      end
      assign regionEnd[g] = regionBase[g] + spanBytes[g];

      assert_size_load_R3: assert property (@(posedge clk) disable iff (!rstN)
        strobe.sizeLoad[g] |=> (sizeQ[g] == $past(cfgWrData)));

      assert_size_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.sizeLoad[g] |=> $stable(sizeQ[g]));
    end
  endgenerate

  assign sizeKb = sizeQ;

endmodule

// File: rtl/csdec_datapath.sv
module csdec_datapath
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 23,
  parameter int SPAN_W = 35
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_strobe_t                   strobe,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [CS_NUM-1:0][SIZE_W-1:0]  sizeKb,
  input  logic [CS_NUM-1:0][SPAN_W-1:0]  regionBase,
  input  logic [CS_NUM-1:0][SPAN_W-1:0]  regionEnd,
  output logic                           rspValid,
  output logic                           rspMiss,
  output logic [CS_IDX_W-1:0]            rspCs,
  output logic [ADDR_W-1:0]              rspOffset
);

  localparam int CMP_W = (ADDR_W > SPAN_W) ? ADDR_W : SPAN_W;

  logic [CMP_W-1:0]    addrExt;
  logic [CS_NUM-1:0]   belowEnd;
  logic [CS_IDX_W-1:0] selIdx;
  logic                missNow;
  logic [ADDR_W-1:0]   offsetNow;

  assign addrExt = CMP_W'(reqAddr);

  generate
    for (genvar g = 0; g < CS_NUM; g++) begin : g_cmp
      assign belowEnd[g] = addrExt < CMP_W'(regionEnd[g]);
    end
  endgenerate

  // R4/R10: lowest region whose end lies above the address; empty ones never win
  always_comb begin
    selIdx = '0;
    for (int i = CS_NUM - 1; i >= 0; i--) begin
      if (belowEnd[i]) selIdx = CS_IDX_W'(i);
    end
  end

  assign missNow   = !belowEnd[CS_NUM-1];
  assign offsetNow = reqAddr - regionBase[selIdx][ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspMiss   <= 1'b0;
      rspCs     <= '0;
      rspOffset <= '0;
    end else begin
      rspValid <= strobe.lookupFire;
      rspMiss  <= strobe.lookupFire && missNow;
      if (strobe.lookupFire && !missNow) begin
        rspCs     <= selIdx;
        rspOffset <= offsetNow;
      end
    end
  end

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookupFire |=> rspValid);

  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lookupFire |=> !rspValid && !rspMiss);

  assert_miss_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss) |-> ($stable(rspCs) && $stable(rspOffset)));

  assert_empty_skipped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookupFire && !missNow) |-> (sizeKb[selIdx] != '0));

  assert_offset_inside_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookupFire && !missNow) |->
      (addrExt >= CMP_W'(regionBase[selIdx])) &&
      (addrExt <  CMP_W'(regionEnd[selIdx])));

  assert_empty_stack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookupFire && (regionEnd[CS_NUM-1] == '0)) |=> rspMiss);

endmodule

// File: rtl/stacked_cs_decoder.sv
module stacked_cs_decoder
  import csdec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 23,
  parameter int KB_SHIFT   = 10,
  parameter int CFG_ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [SIZE_W-1:0]     cfgWrData,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  rspValid,
  output logic                  rspMiss,
  output logic [CS_IDX_W-1:0]   rspCs,
  output logic [ADDR_W-1:0]     rspOffset
);

  localparam int SPAN_W = SIZE_W + KB_SHIFT + CS_IDX_W;

  ctrl_strobe_t                  strobe;
  logic [CS_NUM-1:0][SIZE_W-1:0] sizeKb;
  logic [CS_NUM-1:0][SPAN_W-1:0] regionBase;
  logic [CS_NUM-1:0][SPAN_W-1:0] regionEnd;

  csdec_ctrl #(
    .CFG_ADDR_W (CFG_ADDR_W)
  ) u_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .reqValid (reqValid),
    .strobe   (strobe)
  );

  csdec_size_bank #(
    .SIZE_W   (SIZE_W),
    .KB_SHIFT (KB_SHIFT),
    .SPAN_W   (SPAN_W)
  ) u_bank (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWrData  (cfgWrData),
    .sizeKb     (sizeKb),
    .regionBase (regionBase),
    .regionEnd  (regionEnd)
  );

  csdec_datapath #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .SPAN_W (SPAN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .sizeKb     (sizeKb),
    .regionBase (regionBase),
    .regionEnd  (regionEnd),
    .rspValid   (rspValid),
    .rspMiss    (rspMiss),
    .rspCs      (rspCs),
    .rspOffset  (rspOffset)
  );

endmodule

// File: tb/stacked_cs_decoder_tb.sv
`timescale 1ns/1ps
module stacked_cs_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [22:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic        rspMiss;
  logic [1:0]  rspCs;
  logic [31:0] rspOffset;

  always #10 clk = ~clk;

  stacked_cs_decoder u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .rspValid  (rspValid),
    .rspMiss   (rspMiss),
    .rspCs     (rspCs),
    .rspOffset (rspOffset)
  );

  typedef struct {
    logic        miss;
    logic [1:0]  cs;
    logic [31:0] off;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          testsRun = 0;
  int          testsFail = 0;
  logic [22:0] model[4] = '{default: '0};
  logic [1:0]  lastCs = '0;
  logic [31:0] lastOff = '0;

  function automatic logic [63:0] stackTotal();
    logic [63:0] t = '0;
    for (int i = 0; i < 4; i++) t += {41'd0, model[i]} << 10;
    return t;
  endfunction

  // range-based reference: walks the stacked regions from the bottom
  function automatic exp_t predict(input logic [31:0] a, input string tag);
    exp_t e;
    logic [63:0] lo = '0;
    logic [63:0] len;
    e.miss = 1'b1;
    e.tag  = tag;
    for (int i = 0; i < 4; i++) begin
      len = {41'd0, model[i]} << 10;
      if (e.miss && {32'd0, a} >= lo && {32'd0, a} < lo + len) begin
        e.miss  = 1'b0;
        lastCs  = 2'(i);
        lastOff = 32'({32'd0, a} - lo);
      end
      lo += len;
    end
    e.cs  = lastCs;
    e.off = lastOff;
    return e;
  endfunction

  task automatic lookup(input logic [31:0] a, input string tag);
    @(negedge clk);
    expQ.push_back(predict(a, tag));
    cfgWrEn  = 1'b0;
    reqValid = 1'b1;
    reqAddr  = a;
  endtask

  task automatic writeSize(input logic [3:0] off, input logic [22:0] d);
    @(negedge clk);
    reqValid  = 1'b0;
    cfgWrEn   = 1'b1;
    cfgAddr   = off;
    cfgWrData = d;
    if (off[1:0] == 2'b00) model[off[3:2]] = d;
  endtask

  task automatic writeAndLookup(input logic [3:0] off, input logic [22:0] d,
                                input logic [31:0] a, input string tag);
    @(negedge clk);
    expQ.push_back(predict(a, tag));
    if (off[1:0] == 2'b00) model[off[3:2]] = d;
    cfgWrEn   = 1'b1;
    cfgAddr   = off;
    cfgWrData = d;
    reqValid  = 1'b1;
    reqAddr   = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfgWrEn  = 1'b0;
      reqValid = 1'b0;
    end
  endtask

  // monitor: compares each response against the queue head
  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid) begin
        exp_t e;
        testsRun++;
        if (expQ.size() == 0) begin
          testsFail++;
          $display("FAIL R7 unexpected response: actual rspValid=1 expected 0");
        end else begin
          e = expQ.pop_front();
          if (rspMiss !== e.miss || rspCs !== e.cs || rspOffset !== e.off) begin
            testsFail++;
            $display("FAIL %s: actual miss=%0b cs=%0d off=%h expected miss=%0b cs=%0d off=%h",
                     e.tag, rspMiss, rspCs, rspOffset, e.miss, e.cs, e.off);
          end
        end
      end else if (rspMiss !== 1'b0) begin
        testsRun++;
        testsFail++;
        $display("FAIL R7 miss while idle: actual rspMiss=%0b expected 0", rspMiss);
      end
    end
  end

  initial begin
    #(20 * 150000);
    testsFail++;
    $display("FAIL R7 watchdog: actual run still busy, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    logic [63:0] tot;
    logic [31:0] a;
    repeat (4) @(negedge clk);
    // R8: reset state
    testsRun++;
    if (rspValid !== 1'b0 || rspMiss !== 1'b0 || rspCs !== 2'd0 || rspOffset !== 32'd0) begin
      testsFail++;
      $display("FAIL R8 reset outputs: actual v=%0b m=%0b cs=%0d off=%h expected all zero",
               rspValid, rspMiss, rspCs, rspOffset);
    end
    rstN = 1'b1;
    lookup(32'h0, "R8 empty stack addr 0");
    lookup(32'h1234, "R8 empty stack addr 1234");
    idle(2);

    // sizes: 4 KiB, empty, 2 KiB, 8 KiB -> ends 1000,1000,1800,3800
    writeSize(4'h0, 23'd4);
    writeSize(4'h4, 23'd0);
    writeSize(4'h8, 23'd2);
    writeSize(4'hC, 23'd8);
    lookup(32'h0,    "R1 base of region 0");
    lookup(32'hFFF,  "R10 last byte of region 0");
    lookup(32'h1000, "R4 empty region skipped");
    lookup(32'h17FF, "R6 offset in region 2");
    lookup(32'h1800, "R10 first byte of region 3");
    lookup(32'h37FF, "R2 last byte of region 3");
    lookup(32'h3800, "R5 miss at stack end holds cs/offset");
    lookup(32'h9000_0000, "R5 far miss holds cs/offset");
    idle(1);

    // R3: misaligned and out-of-range writes change nothing
    writeSize(4'h5, 23'd7);
    writeSize(4'hA, 23'd7);
    lookup(32'h1000, "R3 misaligned write ignored");
    lookup(32'h37FF, "R3 sizes unchanged");

    // R9: same-cycle write uses old sizes
    writeAndLookup(4'h0, 23'd1, 32'h800, "R9 old size during write");
    lookup(32'h800, "R9 new size after write");
    lookup(32'h400, "R1 base moves with new size");

    // R2: large region pushes stack past 4 GiB
    writeSize(4'hC, 23'h7FFFFF);
    lookup(32'hFFFF_FFFF, "R2 top of window in large region");
    lookup(32'h0000_0C00, "R2 base of large region");
    idle(1);

    // random sizes and addresses
    for (int k = 0; k < 400; k++) begin
      if (k % 25 == 0) begin
        for (int r = 0; r < 4; r++)
          writeSize(4'(r * 4), ($urandom % 4 == 0) ? 23'd0 : 23'($urandom % 16));
      end
      tot = stackTotal();
      a = 32'($urandom % (32'(tot) + 32'h800));
      lookup(a, "R6 random lookup");
    end
    idle(3);

    testsRun++;
    if (expQ.size() != 0) begin
      testsFail++;
      $display("FAIL R7 responses missing: actual pending=%0d expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule